// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block decides when a bus controller may enter its low-power state and how it leaves that state. The host asks for sleep with one of two request bits. Which bit counts depends on the operating-mode select: the command bit in legacy mode, or the mode bit in extended mode. The request is honoured only while the bus is idle and no interrupt is waiting. The block then enters a grace phase. During this phase the oscillator and the host clock output keep running for a fixed number of bit times, measured with a bit-tick pulse from the bit-timing logic. When the grace phase ends, the block asks for the oscillator to stop.

Three events wake the block: a dominant level on the receive line, the host dropping its sleep request, or a host register access. A wake event asks for the oscillator to restart and sets a sticky wake-up interrupt flag. The host clock output stays gated until the oscillator reports that it is stable. If a wake event arrives during the grace phase, the block goes straight back to normal operation and the oscillator is never stopped. The sequencer itself runs on an always-on clock.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, oscEnable=1, clkOutEn=1, sleepStatus=0 and wakeIrq=0.
- R2: With extMode=0 only cmdSleepReq acts as the sleep request. With extMode=1 only modeSleepReq acts as the request. The unselected bit has no effect.
- R3: Sleep starts only in a cycle where the request is 1, busIdle=1 and irqPending=0. sleepStatus rises one clock after such a cycle.
- R4: Once sleep has started, oscEnable and clkOutEn stay 1 until DELAY_BITS (default 15) bitTick pulses have been sampled. Both drop one clock after the cycle that carries the last of those pulses.
- R5: While oscEnable=0, each of these wakes the block one clock later: rxLevel=0 (dominant), the selected request at 0, or hostAccess=1. On wake, oscEnable returns to 1 and wakeIrq is set.
- R6: After a wake from the stopped state, clkOutEn stays 0 until oscStable=1 is sampled. It becomes 1 one clock after that sample.
- R7: A wake event during the grace phase returns the block to normal operation one clock later, with sleepStatus=0. oscEnable never drops and wakeIrq is set.
- R8: wakeIrq stays 1 until a cycle with wakeIrqClr=1. If a wake event and wakeIrqClr occur in the same cycle, wakeIrq ends up 1.
- R9: sleepStatus is 1 only during the grace phase and the stopped state. It is 0 while the block waits for oscillator stability, even if the request is still set.
- R10: After a wake caused by rxLevel or hostAccess, sleep is not re-entered until the request has been seen at 0 at least once.
- R11: Every grace phase counts its DELAY_BITS pulses from zero. Ticks from an earlier, aborted grace phase do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low synchronous reset |
| extMode | input | 1 | 0 selects legacy request bit, 1 selects extended request bit |
| cmdSleepReq | input | 1 | Sleep request from the command register |
| modeSleepReq | input | 1 | Sleep request from the mode register |
| busIdle | input | 1 | 1 when the bus shows no activity |
| irqPending | input | 1 | 1 when any interrupt is waiting for the host |
| bitTick | input | 1 | One-cycle pulse per nominal bit time |
| rxLevel | input | 1 | Receive line level, 0 is dominant |
| hostAccess | input | 1 | Pulse on any host register access |
| oscStable | input | 1 | Oscillator reports a stable clock |
| wakeIrqClr | input | 1 | Host clear of the wake-up interrupt flag |
| oscEnable | output | 1 | Request to keep the oscillator running |
| clkOutEn | output | 1 | Gate for the host clock output |
| wakeIrq | output | 1 | Sticky wake-up interrupt flag |
| sleepStatus | output | 1 | Host-visible sleep state |

## Verification
The in-line assertions check the transition rules on every cycle. Sleep begins only from an idle, interrupt-free cycle. The oscillator stops only on the closing tick of the grace phase. The clock output returns only after a stable report. The bit counter stays inside its range. The interrupt flag falls only on a clear. The bench scenarios are needed for the exact tick count and for the choice of request bit under each mode. They also cover the rearm rule, counter restart after an aborted grace phase, each wake source, and set-over-clear priority.

// File: rtl/slw_pkg.sv
package slw_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_DELAY  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_WAKING = 2'd3
  } slwState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic irqSet;
  } slwStrobe_t;
endpackage

// File: rtl/slw_datapath.sv
module slw_datapath
  import slw_pkg::*;
#(
  parameter int DELAY_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  slwStrobe_t strb,
  input  logic       wakeIrqClr,
  output logic       cntLast,
  output logic       wakeIrq
);
  localparam int CNT_W = (DELAY_BITS > 2) ? $clog2(DELAY_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_BITS - 1);

  logic [CNT_W-1:0] cntQ;
  logic             irqQ;

  always_ff @(posedge clk) begin
    if (!rstN)            cntQ <= '0;
    else if (strb.cntClr) cntQ <= '0;
    else if (strb.cntInc) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            irqQ <= 1'b0;
    else if (strb.irqSet) irqQ <= 1'b1;
    else if (wakeIrqClr)  irqQ <= 1'b0;
  end

  assign cntLast = (cntQ == LAST);
  assign wakeIrq = irqQ;

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(cntQ) < DELAY_BITS);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqQ) |-> $past(wakeIrqClr));

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.irqSet |=> irqQ);
endmodule

// File: rtl/slw_ctrl.sv
module slw_ctrl
  import slw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extMode,
  input  logic       cmdSleepReq,
  input  logic       modeSleepReq,
  input  logic       busIdle,
  input  logic       irqPending,
  input  logic       bitTick,
  input  logic       rxLevel,
  input  logic       hostAccess,
  input  logic       oscStable,
  input  logic       cntLast,
  output slwStrobe_t strb,
  output logic       oscEnable,
  output logic       clkOutEn,
  output logic       sleepStatus
);
  slwState_e stateQ, stateD;
  logic      sleepReq, wakeEvt, armedQ, sleeping;

  assign sleepReq = extMode ? modeSleepReq : cmdSleepReq;
  assign wakeEvt  = !rxLevel || !sleepReq || hostAccess;
  assign sleeping = (stateQ == ST_DELAY) || (stateQ == ST_ASLEEP);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_ACTIVE: if (sleepReq && armedQ && busIdle && !irqPending) stateD = ST_DELAY;
      ST_DELAY: begin
        if (wakeEvt)                 stateD = ST_ACTIVE;
        else if (bitTick && cntLast) stateD = ST_ASLEEP;
      end
      ST_ASLEEP: if (wakeEvt)   stateD = ST_WAKING;
      ST_WAKING: if (oscStable) stateD = ST_ACTIVE;
      default:                  stateD = ST_ACTIVE;
    endcase
  end

  always_comb begin
    strb.cntClr = (stateQ != ST_DELAY) || (stateD != ST_DELAY);
    strb.cntInc = (stateQ == ST_DELAY) && bitTick && (stateD == ST_DELAY);
    strb.irqSet = sleeping && wakeEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_ACTIVE;
    else       stateQ <= stateD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            armedQ <= 1'b1;
    else if (!sleepReq)   armedQ <= 1'b1;
    else if (strb.irqSet) armedQ <= 1'b0;
  end

  assign oscEnable   = (stateQ != ST_ASLEEP);
  assign clkOutEn    = (stateQ == ST_ACTIVE) || (stateQ == ST_DELAY);
  assign sleepStatus = sleeping;

  // R3
  entry_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DELAY && $past(stateQ) == ST_ACTIVE) |-> $past(busIdle && !irqPending));

  // R4
  stop_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ASLEEP && $past(stateQ) != ST_ASLEEP) |->
      $past(stateQ == ST_DELAY && bitTick && cntLast));

  // R6
  clk_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE && $past(stateQ) == ST_WAKING) |-> $past(oscStable));

  // R7
  abort_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_DELAY && $past(wakeEvt)) |-> (stateQ == ST_ACTIVE));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slw_pkg::*;
#(
  parameter int DELAY_BITS = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic extMode,
  input  logic cmdSleepReq,
  input  logic modeSleepReq,
  input  logic busIdle,
  input  logic irqPending,
  input  logic bitTick,
  input  logic rxLevel,
  input  logic hostAccess,
  input  logic oscStable,
  input  logic wakeIrqClr,
  output logic oscEnable,
  output logic clkOutEn,
  output logic wakeIrq,
  output logic sleepStatus
);
  slwStrobe_t strb;
  logic       cntLast;

  slw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .extMode(extMode), .cmdSleepReq(cmdSleepReq),
    .modeSleepReq(modeSleepReq), .busIdle(busIdle), .irqPending(irqPending),
    .bitTick(bitTick), .rxLevel(rxLevel), .hostAccess(hostAccess),
    .oscStable(oscStable), .cntLast(cntLast), .strb(strb),
    .oscEnable(oscEnable), .clkOutEn(clkOutEn), .sleepStatus(sleepStatus)
  );

  slw_datapath #(.DELAY_BITS(DELAY_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wakeIrqClr(wakeIrqClr),
    .cntLast(cntLast), .wakeIrq(wakeIrq)
  );
endmodule

// File: tb/test_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_wake_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extMode = 0, cmdSleepReq = 0, modeSleepReq = 0, busIdle = 1, irqPending = 0;
  logic bitTick = 0, rxLevel = 1, hostAccess = 0, oscStable = 1, wakeIrqClr = 0;
  logic oscEnable, clkOutEn, wakeIrq, sleepStatus;
  int   nRun = 0, nFail = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl i_sleep_wake_ctrl (
    .clk(clk), .rstN(rstN), .extMode(extMode), .cmdSleepReq(cmdSleepReq),
    .modeSleepReq(modeSleepReq), .busIdle(busIdle), .irqPending(irqPending),
    .bitTick(bitTick), .rxLevel(rxLevel), .hostAccess(hostAccess),
    .oscStable(oscStable), .wakeIrqClr(wakeIrqClr), .oscEnable(oscEnable),
    .clkOutEn(clkOutEn), .wakeIrq(wakeIrq), .sleepStatus(sleepStatus)
  );

  // row bits: {extMode, cmdSleepReq, modeSleepReq, busIdle, irqPending, expectSleep}
  localparam logic [5:0] VEC [8] = '{
    6'b010101,  // R2 legacy, command bit
    6'b001100,  // R2 legacy, mode bit ignored
    6'b101101,  // R2 extended, mode bit
    6'b110100,  // R2 extended, command bit ignored
    6'b111101,  // R2 extended, both set
    6'b010000,  // R3 bus busy
    6'b010110,  // R3 interrupt pending
    6'b000100   // R2 no request
  };

  task automatic chk(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) bitTick = 1;
      @(negedge clk) bitTick = 0;
    end
  endtask

  task automatic clearIrq();
    @(negedge clk) wakeIrqClr = 1;
    @(negedge clk) wakeIrqClr = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 oscEnable", oscEnable, 1);
    chk("R1 clkOutEn", clkOutEn, 1);
    chk("R1 sleepStatus", sleepStatus, 0);
    chk("R1 wakeIrq", wakeIrq, 0);

    for (int i = 0; i < 8; i++) begin
      {extMode, cmdSleepReq, modeSleepReq, busIdle, irqPending} = VEC[i][5:1];
      @(negedge clk);
      chk($sformatf("R2/R3 row%0d sleepStatus", i), sleepStatus, VEC[i][0]);
      cmdSleepReq = 0; modeSleepReq = 0; busIdle = 1; irqPending = 0;
      @(negedge clk);
      chk($sformatf("R7 row%0d wakeIrq", i), wakeIrq, VEC[i][0]);
      clearIrq();
    end
    extMode = 0;

    // full sleep, R4
    cmdSleepReq = 1;
    @(negedge clk);
    chk("R3 enter", sleepStatus, 1);
    ticks(14);
    chk("R4 osc after 14", oscEnable, 1);
    chk("R4 clk after 14", clkOutEn, 1);
    ticks(1);
    chk("R4 osc after 15", oscEnable, 0);
    chk("R4 clk after 15", clkOutEn, 0);
    chk("R9 asleep status", sleepStatus, 1);

    // rx wake, R5 R6 R9
    oscStable = 0; rxLevel = 0;
    @(negedge clk) rxLevel = 1;
    chk("R5 rx osc", oscEnable, 1);
    chk("R5 rx irq", wakeIrq, 1);
    chk("R9 waking status", sleepStatus, 0);
    repeat (3) @(negedge clk);
    chk("R6 gated", clkOutEn, 0);
    oscStable = 1;
    @(negedge clk);
    chk("R6 clk back", clkOutEn, 1);

    // R10 request still high, no re-entry
    repeat (3) @(negedge clk);
    chk("R10 no reentry", sleepStatus, 0);
    chk("R8 held", wakeIrq, 1);
    clearIrq();
    chk("R8 cleared", wakeIrq, 0);

    // R7 abort in delay, R8 priority
    cmdSleepReq = 0;
    @(negedge clk) cmdSleepReq = 1;
    @(negedge clk);
    chk("R10 rearmed", sleepStatus, 1);
    ticks(7);
    hostAccess = 1; wakeIrqClr = 1;
    @(negedge clk) begin hostAccess = 0; wakeIrqClr = 0; end
    chk("R7 active", sleepStatus, 0);
    chk("R7 osc", oscEnable, 1);
    chk("R8 set wins", wakeIrq, 1);
    clearIrq();

    // R11 counter restart
    cmdSleepReq = 0;
    @(negedge clk) cmdSleepReq = 1;
    @(negedge clk);
    ticks(14);
    chk("R11 restart", oscEnable, 1);
    ticks(1);
    chk("R11 stop", oscEnable, 0);

    // hostAccess wake, R5
    hostAccess = 1;
    @(negedge clk) hostAccess = 0;
    chk("R5 host osc", oscEnable, 1);
    chk("R5 host irq", wakeIrq, 1);
    @(negedge clk);
    clearIrq();

    // request-clear wake, R5
    cmdSleepReq = 0;
    @(negedge clk) cmdSleepReq = 1;
    @(negedge clk);
    ticks(15);
    chk("R4 stop again", oscEnable, 0);
    cmdSleepReq = 0;
    @(negedge clk);
    chk("R5 req osc", oscEnable, 1);
    chk("R5 req irq", wakeIrq, 1);
    chk("R6 req gated", clkOutEn, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule